// File: doc/BRIEF.md
# DMA Address Generator with Loop Hold

This block produces the source and destination byte addresses for one DMA channel, one address pair per data beat. A load strobe captures a start address for each side, together with that side's hold configuration taken from the channel mode word. Each advance strobe then moves both addresses on by one byte.

Either side may be placed in hold mode. In hold mode its address cycles through a window of 1, 2, 4 or 8 consecutive bytes that begins at the loaded start address. This is how a channel repeatedly reads a small FIFO-like register set or writes one. Without hold, the address simply increments. The two sides are configured separately. The block issues no bus cycles, counts no bytes and fetches no descriptors.

Top module: `dma_hold_addr_gen`

## Requirements
- R1: While reset is active, and after it is released, both address outputs read zero until the first load.
- R2: When `load_i` is high at a clock edge, each address output equals the start address presented at that edge from the next cycle onward. That side's window position also restarts at zero.
- R3: When `load_i` and `advance_i` are both high at the same edge, the load wins and the advance is discarded.
- R4: With hold disabled on a side, each advance adds one to that side's address. The address wraps modulo 2^ADDR_W.
- R5: With hold enabled and a window of N = 2^k, successive advances give start, start+1, ..., start+N-1 and then start again, repeating.
- R6: With hold enabled and the size field at 0 (window of 1), the address never changes on advance.
- R7: The window is counted from the loaded start address, not aligned to absolute address bits. A start that is not a multiple of N still cycles through exactly N distinct addresses.
- R8: Source and destination hold settings act independently: either side, both sides or neither may loop, each with its own window.
- R9: When neither `load_i` nor `advance_i` is high, both outputs hold their value.
- R10: The mode word fields are read only at load, at these positions:
  - source hold enable at bit 12 and source log2 window size at bits 15:14;
  - destination hold enable at bit 13 and destination log2 window size at bits 17:16;
  - the hold enable is active high.

  Changing `mode_i` between loads has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Capture start addresses and mode fields |
| advance_i | input | 1 | Step both addresses by one beat |
| src_start_i | input | ADDR_W | Source start address |
| dst_start_i | input | ADDR_W | Destination start address |
| mode_i | input | MODE_W | Channel mode word holding the hold enable and size fields |
| src_addr_o | output | ADDR_W | Current source address |
| dst_addr_o | output | ADDR_W | Current destination address |

## Verification
The case hardest to reach from the ports is a wrap that coincides with something else. One example is a window wrap on one side while the other side increments freely across the top of the address space. Another is a wrap beat that arrives together with a load. The random stimulus draws start addresses close to all-ones and unaligned to the window. It also keeps advances dense, so wraps occur often and in many phases. Directed sequences separately force a simultaneous load and advance, a window of one, and a mode word changed between loads.

// File: rtl/dma_hold_addr_gen_pkg.sv
package dma_hold_addr_gen_pkg;
  localparam int LG_W  = 2;
  localparam int OFF_W = 4;

  typedef struct packed {
    logic            hold;
    logic [LG_W-1:0] lg;
  } side_cfg_t;

  function automatic logic [OFF_W-1:0] win_last(input logic [LG_W-1:0] lg);
    return OFF_W'((1 << lg) - 1);
  endfunction
endpackage

// File: rtl/dma_hold_mode_decode.sv
module dma_hold_mode_decode
  import dma_hold_addr_gen_pkg::*;
#(
  parameter int MODE_W   = 32,
  parameter int HOLD_BIT = 12,
  parameter int SIZE_LSB = 14
) (
  input  logic [MODE_W-1:0] mode_i,
  output side_cfg_t         cfg_o
);
  always_comb begin
    cfg_o.hold = mode_i[HOLD_BIT];
    cfg_o.lg   = mode_i[SIZE_LSB +: LG_W];
  end
endmodule

// File: rtl/dma_hold_side.sv
module dma_hold_side
  import dma_hold_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_i,
  input  side_cfg_t         cfg_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] off_q, off_d;
  side_cfg_t         cfg_q, cfg_d;
  logic              en;
  logic              at_last;

  assign at_last = (off_q == ADDR_W'(win_last(cfg_q.lg)));
  assign en      = load_i | adv_i;

  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    cfg_d  = cfg_q;
    if (load_i) begin
      base_d = start_i;
      off_d  = '0;
      cfg_d  = cfg_i;
    end else if (adv_i) begin
      if (cfg_q.hold && at_last) off_d = '0;
      else                       off_d = off_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      cfg_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      off_q  <= off_d;
      cfg_q  <= cfg_d;
    end
  end

  assign addr_o = base_q + off_q;
endmodule

// File: rtl/dma_hold_addr_gen.sv
module dma_hold_addr_gen
  import dma_hold_addr_gen_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int MODE_W       = 32,
  parameter int SRC_HOLD_BIT = 12,
  parameter int DST_HOLD_BIT = 13,
  parameter int SRC_SIZE_LSB = 14,
  parameter int DST_SIZE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o
);
  localparam int NSIDE = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  localparam int HOLD_BITS [NSIDE] = '{SRC_HOLD_BIT, DST_HOLD_BIT};
  localparam int SIZE_LSBS [NSIDE] = '{SRC_SIZE_LSB, DST_SIZE_LSB};

  logic [ADDR_W-1:0] starts [NSIDE];
  logic [ADDR_W-1:0] addrs  [NSIDE];
  side_cfg_t         cfgs   [NSIDE];

  assign starts[0] = src_start_i;
  assign starts[1] = dst_start_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_hold_mode_decode #(
      .MODE_W  (MODE_W),
      .HOLD_BIT(HOLD_BITS[s]),
      .SIZE_LSB(SIZE_LSBS[s])
    ) dec_i (
      .mode_i(mode_i),
      .cfg_o (cfgs[s])
    );

    dma_hold_side #(.ADDR_W(ADDR_W)) side_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .load_i (load_i),
      .adv_i  (advance_i),
      .start_i(starts[s]),
      .cfg_i  (cfgs[s]),
      .addr_o (addrs[s])
    );
  end

  assign src_addr_o = addrs[0];
  assign dst_addr_o = addrs[1];
endmodule

// File: rtl/dma_hold_addr_gen_chk.sv
module dma_hold_addr_gen_chk #(
  parameter int ADDR_W       = 32,
  parameter int MODE_W       = 32,
  parameter int SRC_HOLD_BIT = 12,
  parameter int DST_HOLD_BIT = 13,
  parameter int SRC_SIZE_LSB = 14,
  parameter int DST_SIZE_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              advance_i,
  input logic [ADDR_W-1:0] src_start_i,
  input logic [ADDR_W-1:0] dst_start_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o
);
  logic              s_hold_q, d_hold_q;
  logic [1:0]        s_lg_q, d_lg_q;
  logic [ADDR_W-1:0] s_base_q, d_base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hold_q <= 1'b0; d_hold_q <= 1'b0;
      s_lg_q   <= '0;   d_lg_q   <= '0;
      s_base_q <= '0;   d_base_q <= '0;
    end else if (load_i) begin
      s_hold_q <= mode_i[SRC_HOLD_BIT];
      d_hold_q <= mode_i[DST_HOLD_BIT];
      s_lg_q   <= mode_i[SRC_SIZE_LSB +: 2];
      d_lg_q   <= mode_i[DST_SIZE_LSB +: 2];
      s_base_q <= src_start_i;
      d_base_q <= dst_start_i;
    end
  end

  // R2
  load_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (src_addr_o == $past(src_start_i)) && (dst_addr_o == $past(dst_start_i)));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o)));

  // R4
  src_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && advance_i && !s_hold_q) |=> (src_addr_o == $past(src_addr_o) + ADDR_W'(1)));

  // R4
  dst_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && advance_i && !d_hold_q) |=> (dst_addr_o == $past(dst_addr_o) + ADDR_W'(1)));

  // R5
  src_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_hold_q |-> ((src_addr_o - s_base_q) < ADDR_W'(1 << s_lg_q)));

  // R5
  dst_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_hold_q |-> ((dst_addr_o - d_base_q) < ADDR_W'(1 << d_lg_q)));

  // R6
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && s_hold_q && s_lg_q == 2'd0) |=> $stable(src_addr_o));

  // R6
  dst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && d_hold_q && d_lg_q == 2'd0) |=> $stable(dst_addr_o));
endmodule

bind dma_hold_addr_gen dma_hold_addr_gen_chk #(
  .ADDR_W(ADDR_W), .MODE_W(MODE_W),
  .SRC_HOLD_BIT(SRC_HOLD_BIT), .DST_HOLD_BIT(DST_HOLD_BIT),
  .SRC_SIZE_LSB(SRC_SIZE_LSB), .DST_SIZE_LSB(DST_SIZE_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
  .src_start_i(src_start_i), .dst_start_i(dst_start_i), .mode_i(mode_i),
  .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o)
);

// File: tb/dma_hold_addr_gen_tb_top.sv
module dma_hold_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int MW = 32;

  logic          clk;
  logic          rst_n;
  logic          load_i, advance_i;
  logic [AW-1:0] src_start_i, dst_start_i;
  logic [MW-1:0] mode_i;
  logic [AW-1:0] src_addr_o, dst_addr_o;

  int n_cmp, n_bad;
  bit done;

  // bench model state: index 0 source, 1 destination
  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_off  [2];
  logic          m_hold [2];
  logic [1:0]    m_lg   [2];

  dma_hold_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
    .src_start_i(src_start_i), .dst_start_i(dst_start_i), .mode_i(mode_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [MW-1:0] mk_mode(input bit sh, input int sl, input bit dh, input int dl);
    logic [MW-1:0] m;
    m = MW'($urandom);
    m[12] = sh; m[13] = dh;
    m[15:14] = 2'(sl); m[17:16] = 2'(dl);
    return m;
  endfunction

  function automatic logic [AW-1:0] next_off(input logic [AW-1:0] off, input logic hold, input logic [1:0] lg);
    if (hold && off == AW'((1 << lg) - 1)) return '0;
    return off + AW'(1);
  endfunction

  function automatic string tag_of(input int s);
    if (!m_hold[s])      return "R4";
    if (m_lg[s] == 2'd0) return "R6";
    return "R5";
  endfunction

  task automatic model_edge();
    if (load_i) begin
      m_base[0] = src_start_i; m_base[1] = dst_start_i;
      m_off[0] = '0; m_off[1] = '0;
      m_hold[0] = mode_i[12]; m_hold[1] = mode_i[13];
      m_lg[0] = mode_i[15:14]; m_lg[1] = mode_i[17:16];
    end else if (advance_i) begin
      for (int s = 0; s < 2; s++) m_off[s] = next_off(m_off[s], m_hold[s], m_lg[s]);
    end
  endtask

  task automatic check(input string tag, input string tag2);
    logic [AW-1:0] es, ed;
    es = m_base[0] + m_off[0];
    ed = m_base[1] + m_off[1];
    n_cmp++;
    if (src_addr_o !== es) begin
      n_bad++;
      $display("FAIL %s src: actual %h expected %h", tag, src_addr_o, es);
    end
    n_cmp++;
    if (dst_addr_o !== ed) begin
      n_bad++;
      $display("FAIL %s dst: actual %h expected %h", tag2, dst_addr_o, ed);
    end
  endtask

  // drive at negedge, model the coming edge, check at the next negedge
  task automatic step(input bit ld, input bit adv, input string tag, input string tag2);
    load_i = ld; advance_i = adv;
    model_edge();
    @(negedge clk);
    check(tag, tag2);
  endtask

  task automatic do_load(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [MW-1:0] m);
    src_start_i = s; dst_start_i = d; mode_i = m;
    step(1'b1, 1'b0, "R2", "R2");
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    load_i = 0; advance_i = 0; src_start_i = '0; dst_start_i = '0; mode_i = '0;
    for (int s = 0; s < 2; s++) begin
      m_base[s] = '0; m_off[s] = '0; m_hold[s] = 0; m_lg[s] = '0;
    end
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", "R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", "R1");

    // R3: load and advance together, load wins
    src_start_i = 32'h100; dst_start_i = 32'h200; mode_i = mk_mode(0, 0, 0, 0);
    step(1'b1, 1'b1, "R3", "R3");

    // R6 source window of one, R4 destination free
    do_load(32'h1003, 32'hFFFF_FFFE, mk_mode(1, 0, 0, 3));
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R6", "R4");

    // R7 unaligned start, window 4 src, window 8 dst (R8 independent)
    do_load(32'h0000_2006, 32'h0000_3005, mk_mode(1, 2, 1, 3));
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1, "R7", "R8");

    // R9 idle, R10 mode change between loads ignored
    mode_i = mk_mode(0, 1, 0, 1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R9", "R9");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R10", "R10");

    // R8 source free, destination window 2
    do_load(32'hFFFF_FFFD, 32'h0000_0041, mk_mode(0, 3, 1, 1));
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R8", "R5");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) begin
        src_start_i = ($urandom_range(0, 1) != 0) ? (32'hFFFF_FFF0 | AW'($urandom_range(0, 15))) : AW'($urandom);
        dst_start_i = ($urandom_range(0, 1) != 0) ? (32'hFFFF_FFF0 | AW'($urandom_range(0, 15))) : AW'($urandom);
        mode_i = MW'($urandom);
        step(1'b1, ($urandom_range(0, 1) != 0), "R2", "R3");
      end else if (r < 78) begin
        string t0, t1;
        t0 = tag_of(0); t1 = tag_of(1);
        if ($urandom_range(0, 3) == 0) mode_i = MW'($urandom);
        step(1'b0, 1'b1, t0, t1);
      end else begin
        step(1'b0, 1'b0, "R9", "R9");
      end
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule